// File: doc/BRIEF.md
# Shared Buffer Block Pool Manager

This block hands out and takes back the fixed-size blocks of a shared packet buffer. Free block numbers live on a last-in, first-out stack: an ingress writer asks for a block and receives the number on top of the stack in the same cycle. Each block also carries a reader count. A writer can load that count with the number of egress ports that will read the block, which matters when a frame goes to several ports at once.

Every egress reader issues a release when it is finished with a block, and each release lowers the count by one. The block number goes back onto the stack only when its count drops to zero, so a block shared by several readers stays reserved until the last of them is done. A release aimed at a block whose count is already zero is reported and otherwise has no effect. This guards the pool against a block being freed twice.

Top module: `pool_mgr`

## Requirements
- R1: After reset all NUM_BLOCKS block numbers are free, `pool_empty` is 0 and `alloc_idx` shows NUM_BLOCKS-1.
- R2: The free stack is last-in, first-out. `alloc_idx` always shows the most recently pushed free number, and a granted request pops it at the clock edge.
- R3: `pool_empty` is 1 exactly when no number is free. While it is 1, `alloc_gnt` stays 0 and a request changes nothing.
- R4: A granted allocation loads the block's reader count with 1, so a single release returns the block to the stack.
- R5: `set_vld` with a nonzero `set_cnt` loads that value into block `set_idx`. The block is pushed back only on the release that takes its count from 1 to 0.
- R6: `set_vld` with `set_cnt` equal to 0 is ignored, and the block keeps its count.
- R7: A release of a block whose count is 0 sets `rel_err` in the following cycle and leaves the stack and all counts unchanged. Otherwise `rel_err` is 0.
- R8: An allocation and a freeing release in the same cycle are both honoured. The granted number is the old top, the freed number becomes the new top, and the free level is unchanged.
- R9: When a nonzero load and a release target the same block in one cycle, the load wins and the release is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request one free block |
| alloc_gnt | output | 1 | Request is granted this cycle |
| alloc_idx | output | IDX_W | Block number on top of the free stack |
| pool_empty | output | 1 | No free block available |
| set_vld | input | 1 | Load a block's reader count |
| set_idx | input | IDX_W | Block whose count is loaded |
| set_cnt | input | CNT_W | Reader count to load (0 is ignored) |
| rel_vld | input | 1 | One reader is done with a block |
| rel_idx | input | IDX_W | Block being released |
| rel_err | output | 1 | Previous cycle's release hit a zero count |

## Verification
The bench uses the default build: 64 blocks and a 3-bit reader count. With 64 blocks the bench can fully drain the pool within a short directed run, so it can check the empty boundary, a refused request and a release that refills an empty stack. With the 3-bit count the bench can load shared counts of up to four readers in random traffic. It can also create double releases on purpose, to confirm that they cannot corrupt the stack.

// File: rtl/pool_pkg.sv
package pool_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/pool_stack.sv
module pool_stack
  import pool_pkg::*;
#(
  parameter int NB = 64,
  parameter int IW = $clog2(NB),
  parameter int SW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] top_idx,
  output logic          empty,
  output logic [SW-1:0] level
);
  logic [IW-1:0] mem_q [NB];
  logic [IW-1:0] mem_d [NB];
  logic [SW-1:0] sp_q, sp_d;
  logic [IW-1:0] top_ptr, put_ptr;
  stk_op_e       op;
  logic          mem_en;

  assign top_ptr = IW'(sp_q - 1'b1);
  assign put_ptr = IW'(sp_q);
  assign top_idx = mem_q[top_ptr];
  assign empty   = (sp_q == '0);
  assign level   = sp_q;

  always_comb begin
    case ({push, pop})
      2'b10:   op = STK_PUSH;
      2'b01:   op = STK_POP;
      2'b11:   op = STK_SWAP;
      default: op = STK_HOLD;
    endcase
  end

  // R2/R8: next-state of pointer and storage
  always_comb begin
    mem_d  = mem_q;
    sp_d   = sp_q;
    mem_en = 1'b0;
    case (op)
      STK_PUSH: begin
        mem_d[put_ptr] = push_idx;
        sp_d           = sp_q + 1'b1;
        mem_en         = 1'b1;
      end
      STK_POP:  sp_d = sp_q - 1'b1;
      STK_SWAP: begin
        mem_d[top_ptr] = push_idx;
        mem_en         = 1'b1;
      end
      default: ;
    endcase
  end

  // R1: reset loads every block number
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SW'(NB);
      for (int i = 0; i < NB; i++) mem_q[i] <= IW'(i);
    end else begin
      if (op != STK_HOLD) sp_q <= sp_d;
      if (mem_en) mem_q <= mem_d;
    end
  end
endmodule

// File: rtl/pool_refcnt.sv
module pool_refcnt #(
  parameter int NB = 64,
  parameter int IW = $clog2(NB),
  parameter int CW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_fire,
  input  logic [IW-1:0]  alloc_idx,
  input  logic           set_vld,
  input  logic [IW-1:0]  set_idx,
  input  logic [CW-1:0]  set_cnt,
  input  logic           rel_vld,
  input  logic [IW-1:0]  rel_idx,
  output logic           rel_free,
  output logic           rel_bad,
  output logic [NB*CW-1:0] cnt_all
);
  logic          set_ok, rel_live;
  logic [CW-1:0] cur_cnt;

  assign set_ok   = set_vld && (set_cnt != '0);           // R6
  assign rel_live = rel_vld && !(set_ok && set_idx == rel_idx); // R9
  assign cur_cnt  = cnt_all[rel_idx*CW +: CW];
  assign rel_bad  = rel_live && (cur_cnt == '0);          // R7
  assign rel_free = rel_live && (cur_cnt == CW'(1));      // R5

  for (genvar i = 0; i < NB; i++) begin : g_blk
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit_set, hit_alloc, hit_rel, cnt_en;

    assign hit_set   = set_ok && (set_idx == IW'(i));
    assign hit_alloc = alloc_fire && (alloc_idx == IW'(i));
    assign hit_rel   = rel_live && (rel_idx == IW'(i)) && (cnt_q != '0);
    assign cnt_en    = hit_set || hit_alloc || hit_rel;

    always_comb begin
      if (hit_set)        cnt_d = set_cnt;
      else if (hit_alloc) cnt_d = CW'(1);   // R4
      else if (hit_rel)   cnt_d = cnt_q - 1'b1;
      else                cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign cnt_all[i*CW +: CW] = cnt_q;
  end
endmodule

// File: rtl/pool_mgr.sv
module pool_mgr #(
  parameter int NUM_BLOCKS = 64,
  parameter int MAX_REF    = 4,
  parameter int IDX_W      = $clog2(NUM_BLOCKS),
  parameter int CNT_W      = $clog2(MAX_REF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  output logic             alloc_gnt,
  output logic [IDX_W-1:0] alloc_idx,
  output logic             pool_empty,
  input  logic             set_vld,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [CNT_W-1:0] set_cnt,
  input  logic             rel_vld,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             rel_err
);
  localparam int LVL_W = $clog2(NUM_BLOCKS + 1);

  logic                      rel_free, rel_bad;
  logic [LVL_W-1:0]          level;
  logic [NUM_BLOCKS*CNT_W-1:0] cnt_all;
  logic                      err_q;

  assign alloc_gnt = alloc_req && !pool_empty;  // R3

  pool_stack #(.NB(NUM_BLOCKS), .IW(IDX_W), .SW(LVL_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rel_free),
    .push_idx (rel_idx),
    .pop      (alloc_gnt),
    .top_idx  (alloc_idx),
    .empty    (pool_empty),
    .level    (level)
  );

  pool_refcnt #(.NB(NUM_BLOCKS), .IW(IDX_W), .CW(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_gnt),
    .alloc_idx  (alloc_idx),
    .set_vld    (set_vld),
    .set_idx    (set_idx),
    .set_cnt    (set_cnt),
    .rel_vld    (rel_vld),
    .rel_idx    (rel_idx),
    .rel_free   (rel_free),
    .rel_bad    (rel_bad),
    .cnt_all    (cnt_all)
  );

  // R7: error pulse one cycle after the offending release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= rel_bad;
  end
  assign rel_err = err_q;
endmodule

// File: rtl/pool_mgr_chk.sv
module pool_mgr_chk #(
  parameter int NB = 64,
  parameter int IW = 6,
  parameter int CW = 3,
  parameter int SW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_gnt,
  input logic          pool_empty,
  input logic          rel_vld,
  input logic          rel_err,
  input logic          rel_free,
  input logic [SW-1:0] level,
  input logic          set_vld,
  input logic [IW-1:0] set_idx,
  input logic [CW-1:0] set_cnt,
  input logic [NB*CW-1:0] cnt_all
);
  function automatic logic [CW-1:0] cnt_of(logic [NB*CW-1:0] v, logic [IW-1:0] k);
    return v[k*CW +: CW];
  endfunction

  a_r3_no_grant_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pool_empty |-> !alloc_gnt);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= SW'(NB));

  a_r8_swap_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && rel_free) |=> level == $past(level));

  a_r2_pop_lowers_level: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !rel_free) |=> level == $past(level) - 1'b1);

  a_r7_err_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_vld));

  a_r5_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && set_cnt != '0) |=> cnt_of(cnt_all, $past(set_idx)) == $past(set_cnt));
endmodule

bind pool_mgr pool_mgr_chk #(
  .NB(NUM_BLOCKS), .IW(IDX_W), .CW(CNT_W), .SW(LVL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_gnt  (alloc_gnt),
  .pool_empty (pool_empty),
  .rel_vld    (rel_vld),
  .rel_err    (rel_err),
  .rel_free   (rel_free),
  .level      (level),
  .set_vld    (set_vld),
  .set_idx    (set_idx),
  .set_cnt    (set_cnt),
  .cnt_all    (cnt_all)
);

// File: tb/pool_mgr_tb.sv
`timescale 1ns/100ps
module pool_mgr_tb;
  localparam int NB = 64;
  localparam int IW = 6;
  localparam int CW = 3;

  logic          clk, rst_n;
  logic          alloc_req, alloc_gnt, pool_empty, set_vld, rel_vld, rel_err;
  logic [IW-1:0] alloc_idx, set_idx, rel_idx;
  logic [CW-1:0] set_cnt;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench reference model
  int mstk [NB];
  int mcnt [NB];
  int msp;

  pool_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
    .alloc_idx(alloc_idx), .pool_empty(pool_empty), .set_vld(set_vld),
    .set_idx(set_idx), .set_cnt(set_cnt), .rel_vld(rel_vld),
    .rel_idx(rel_idx), .rel_err(rel_err)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_top();
    return (msp > 0) ? mstk[msp-1] : -1;
  endfunction

  // one cycle: drive at negedge, check outputs, update model at posedge
  task automatic step(bit a, bit s, int si, int sc, bit r, int ri, string tag);
    bit sethit, gnt, push, eerr;
    int pidx, old;
    alloc_req = a; set_vld = s; set_idx = IW'(si); set_cnt = CW'(sc);
    rel_vld = r; rel_idx = IW'(ri);
    #1;
    chk({tag, " R3 empty"}, pool_empty, msp == 0);
    chk({tag, " R3 grant"}, alloc_gnt, a && msp > 0);
    if (msp > 0) chk({tag, " R2 top"}, alloc_idx, exp_top());
    sethit = s && sc != 0 && r && si == ri;
    gnt  = a && msp > 0;
    pidx = exp_top();
    old  = mcnt[ri];
    eerr = r && !sethit && old == 0;
    push = r && !sethit && old == 1;
    @(posedge clk);
    if (r && !sethit && old != 0) mcnt[ri] = old - 1;
    if (gnt) mcnt[pidx] = 1;
    if (s && sc != 0) mcnt[si] = sc;
    if (push && gnt) mstk[msp-1] = ri;
    else if (push) begin mstk[msp] = ri; msp++; end
    else if (gnt) msp--;
    @(negedge clk);
    chk({tag, " R7 err"}, rel_err, eerr);
    alloc_req = 0; set_vld = 0; rel_vld = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    alloc_req = 0; set_vld = 0; rel_vld = 0;
    set_idx = 0; set_cnt = 0; rel_idx = 0;
    rst_n = 0;
    msp = NB;
    for (int i = 0; i < NB; i++) begin mstk[i] = i; mcnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 empty after reset", pool_empty, 0);
    chk("R1 top after reset", alloc_idx, NB - 1);
    // R2: drain in LIFO order, R3 at the boundary
    for (int i = 0; i < NB; i++) step(1, 0, 0, 0, 0, 0, "R2 drain");
    chk("R3 empty after drain", pool_empty, 1);
    step(1, 0, 0, 0, 0, 0, "R3 request while empty");
    // R4: single release frees an allocated block
    step(0, 0, 0, 0, 1, 10, "R4 release");
    chk("R4 freed block on top", alloc_idx, 10);
    step(1, 0, 0, 0, 0, 0, "R4 realloc");
    // R5: shared count of three
    step(0, 1, 10, 3, 0, 0, "R5 load");
    step(0, 0, 0, 0, 1, 10, "R5 rel1");
    chk("R5 still held", pool_empty, 1);
    step(0, 0, 0, 0, 1, 10, "R5 rel2");
    chk("R5 still held", pool_empty, 1);
    step(0, 0, 0, 0, 1, 10, "R5 rel3");
    chk("R5 freed after last", alloc_idx, 10);
    // R7: double release
    step(0, 0, 0, 0, 1, 10, "R7 double release");
    chk("R7 top unchanged", alloc_idx, 10);
    // R6: load of zero ignored, block 20 keeps count 1
    step(0, 1, 20, 0, 0, 0, "R6 zero load");
    step(0, 0, 0, 0, 1, 20, "R6 release after zero load");
    chk("R6 block 20 freed", alloc_idx, 20);
    // R8: allocate and free together
    step(1, 0, 0, 0, 1, 30, "R8 swap");
    chk("R8 new top", alloc_idx, 30);
    // R9: load and release on same block
    step(0, 1, 40, 2, 1, 40, "R9 load wins");
    step(0, 0, 0, 0, 1, 40, "R9 rel1");
    step(0, 0, 0, 0, 1, 40, "R9 rel2");
    chk("R9 freed after two", alloc_idx, 40);
    // random mix covering R2 R4 R5 R7 R8
    for (int n = 0; n < 4000; n++) begin
      int ri, si, k;
      bit a, s, r;
      a = ($urandom % 100) < 45;
      s = ($urandom % 100) < 15;
      r = ($urandom % 100) < 55;
      ri = $urandom % NB;
      if (($urandom % 100) < 90)
        for (k = 0; k < NB && mcnt[(ri + k) % NB] == 0; k++) ;
      else k = 0;
      ri = (ri + k) % NB;
      si = $urandom % NB;
      for (k = 0; k < NB && mcnt[(si + k) % NB] == 0; k++) ;
      si = (si + k) % NB;
      step(a, s, si, $urandom % 5, r, ri, "R5 R8 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule